// File: doc/BRIEF.md
# Double-Buffered Down-Counter Timer Bank

The block holds a small set of down-counting timer channels that share one control word. Each channel has a count buffer and a live counter; channels other than the last also have a compare buffer that is stored and read back but drives no output. Software writes a buffer and then raises the channel's manual-update bit, which copies the buffer into the live counter. Raising the start bit lets the counter run, and it steps down by one on every cycle in which that channel's tick enable is high. The tick enables come from a prescaler outside the block.

When a running counter sees a tick while it holds zero, the channel expires. The next cycle brings a one-cycle pulse on its expiry output. With auto-reload set, the counter takes the count buffer again and keeps running. With auto-reload clear, the counter stays at zero and the block clears that channel's start bit in the shared control word by itself. The live counter of each channel can be read at an observation address. Control bits act only on their 0→1 and 1→0 transitions between the stored word and the newly written word.

Top module: `tmr_bank`

## Requirements
- R1: After reset the control word, every count buffer, every compare buffer and every live counter read 0, all channels are stopped and no expiry output is high.
- R2: In the control word, channel 0 uses bits 0..3 and channel k≥1 has base bit 4+4k. From the base: start is +0, manual update +1, output invert +2 (stored only) and auto-reload +3. The last channel has no invert bit, and its auto-reload is at base+2 (bit 22 with five channels).
- R3: Word addresses: 0x00 is the control word. Channel k uses 0x04+4k for its count buffer, +1 for its compare buffer and +2 for its observation register. Writes to the observation register are ignored. The last channel's compare address reads 0 and ignores writes.
- R4: A control write that takes a channel's manual-update bit from 0 to 1 copies its count buffer into its live counter. A write that leaves the bit at 1 does not reload.
- R5: While the start bit is 1, the counter decrements by one on each cycle with its tick enable high. Writing start 1→0 stops it with the value held, and ticks have no effect on a stopped channel.
- R6: A tick while a running counter is 0 is an expiry. The expiry output is high for exactly the one cycle after that tick's clock edge. A counter started at N expires on its (N+1)th tick.
- R7: On expiry with auto-reload set, the counter reloads from the count buffer, the start bit stays 1 and counting goes on.
- R8: On expiry with auto-reload clear, the counter stays 0 and the channel's start bit reads back 0.
- R9: If an expiry that clears the start bit coincides with a software control write that keeps that start bit at 1, the bit ends at 0, while the write's other bits are taken.
- R10: A single write raising both manual update and start loads the counter and then runs from the loaded value.
- R11: A tick in the same cycle as a manual-update load does not decrement the newly loaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | DATA_W | Read data, combinational from rd_addr |
| tick_en | input | NUM_CH | Per-channel count enable |
| expire_o | output | NUM_CH | Per-channel one-cycle expiry pulse |

## Verification
The bench walks counts of 0, small and larger values through each channel with and without auto-reload. A design off by one on the zero tick would fire a tick early or late, and one that ignored auto-reload would stop after one pulse or never stop. Directed cases write the manual-update bit while it is already 1, which a level-sensitive design would treat as a reload, and they tick in the very cycle of a load, which a design with the wrong priority would decrement. One case lets an expiry collide with a control write that rewrites start as 1. A design that lets software win would leave the channel running with a zero count. The last channel is run with auto-reload only at bit 22, so a design using the common base+3 layout there would stop it.

// File: rtl/tmr_bank_pkg.sv
package tmr_bank_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_CNTB,
    SEL_CMPB,
    SEL_OBS
  } sel_e;

  typedef struct packed {
    sel_e       sel;
    logic [7:0] ch;
  } dec_t;

  // lowest control bit owned by a channel
  function automatic int unsigned ch_base(input int unsigned ch);
    return (ch == 0) ? 0 : 4 + 4 * ch;
  endfunction

  function automatic int unsigned start_pos(input int unsigned ch);
    return ch_base(ch);
  endfunction

  function automatic int unsigned mupd_pos(input int unsigned ch);
    return ch_base(ch) + 1;
  endfunction

  // the last channel lacks the invert bit, so auto-reload moves down one
  function automatic int unsigned arld_pos(input int unsigned ch, input int unsigned n);
    return (ch == n - 1) ? ch_base(ch) + 2 : ch_base(ch) + 3;
  endfunction

  function automatic dec_t decode(input logic [31:0] a, input int unsigned n);
    dec_t d;
    logic [31:0] rel;
    d.sel = SEL_NONE;
    d.ch  = '0;
    rel   = a - 32'd4;
    if (a == 32'd0) begin
      d.sel = SEL_CTRL;
    end else if (a >= 32'd4 && rel < 4 * n) begin
      d.ch = 8'(rel >> 2);
      case (rel[1:0])
        2'd0:    d.sel = SEL_CNTB;
        2'd1:    d.sel = SEL_CMPB;
        2'd2:    d.sel = SEL_OBS;
        default: d.sel = SEL_NONE;
      endcase
    end
    return d;
  endfunction

endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_bank_pkg::*;
#(
  parameter int unsigned NUM_CH = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [NUM_CH-1:0] expire_now_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [NUM_CH-1:0] run_o,
  output logic [NUM_CH-1:0] load_o,
  output logic [NUM_CH-1:0] arld_o
);

  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] clr_mask;
  logic [DATA_W-1:0] ctrl_d;
  logic [NUM_CH-1:0] stop_req;
  logic [NUM_CH-1:0] hw_clr;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam int unsigned ST = start_pos(g);
    localparam int unsigned MU = mupd_pos(g);
    localparam int unsigned AR = arld_pos(g, NUM_CH);

    // edges are taken between the stored word and the written word
    assign load_o[g]   = wr_i & wr_data_i[MU] & ~ctrl_q[MU];
    assign stop_req[g] = wr_i & ~wr_data_i[ST] & ctrl_q[ST];
    assign run_o[g]    = ctrl_q[ST] & ~stop_req[g];
    assign arld_o[g]   = ctrl_q[AR];
    assign hw_clr[g]   = expire_now_i[g] & ~ctrl_q[AR];

    // R9: hardware clear wins over a same-cycle software write
    a_r9_hw_clear : assert property (@(posedge clk) disable iff (!rst_n)
      hw_clr[g] |=> !ctrl_q[ST]);

    // R8: a one-shot expiry leaves the channel stopped
    a_r8_stops : assert property (@(posedge clk) disable iff (!rst_n)
      hw_clr[g] |=> !run_o[g]);
  end

  always_comb begin
    clr_mask = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (hw_clr[i]) clr_mask[start_pos(i)] = 1'b1;
    end
    ctrl_d = (wr_i ? wr_data_i : ctrl_q) & ~clr_mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cntb_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              tick_i,
  input  logic              run_i,
  input  logic              load_i,
  input  logic              arld_i,
  output logic [DATA_W-1:0] cntb_o,
  output logic [DATA_W-1:0] cnt_o,
  output logic              expire_now_o,
  output logic              expire_o
);

  logic [DATA_W-1:0] cntb_q;
  logic [DATA_W-1:0] cnt_q;
  logic              expire_q;
  logic              step;

  // priority: manual load, then reload on expiry, then plain decrement
  function automatic logic [DATA_W-1:0] next_count(
    input logic [DATA_W-1:0] cur,
    input logic [DATA_W-1:0] bufv,
    input logic              ld,
    input logic              exp,
    input logic              ar,
    input logic              dec
  );
    if (ld)            return bufv;
    else if (exp & ar) return bufv;
    else if (dec)      return cur - 1'b1;
    else               return cur;
  endfunction

  assign expire_now_o = run_i & tick_i & (cnt_q == '0);
  assign step         = run_i & tick_i & (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cntb_q   <= '0;
      cnt_q    <= '0;
      expire_q <= 1'b0;
    end else begin
      if (wr_cntb_i) cntb_q <= wr_data_i;
      cnt_q    <= next_count(cnt_q, cntb_q, load_i, expire_now_o, arld_i, step);
      expire_q <= expire_now_o;
    end
  end

  assign cntb_o   = cntb_q;
  assign cnt_o    = cnt_q;
  assign expire_o = expire_q;

  // R4: a rising manual-update bit loads the buffer
  a_r4_load : assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> cnt_q == $past(cntb_q));

  // R5: one step down per tick while running
  a_r5_dec : assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load_i) |=> cnt_q == $past(cnt_q) - 1'b1);

  // R5: a stopped channel holds its value
  a_r5_hold : assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !load_i) |=> $stable(cnt_q));

  // R7: auto-reload restores the buffer value on expiry
  a_r7_reload : assert property (@(posedge clk) disable iff (!rst_n)
    (expire_now_o && arld_i && !load_i) |=> cnt_q == $past(cntb_q));

  // R6: the pulse follows the expiring tick by one edge
  a_r6_pulse : assert property (@(posedge clk) disable iff (!rst_n)
    expire_now_o |=> expire_o);

endmodule

// File: rtl/tmr_rdmux.sv
module tmr_rdmux
  import tmr_bank_pkg::*;
#(
  parameter int unsigned NUM_CH = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0]              rd_addr_i,
  input  logic [DATA_W-1:0]              ctrl_i,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  cntb_i,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  cmpb_i,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  cnt_i,
  output logic [DATA_W-1:0]              rd_data_o
);

  dec_t rdec;

  always_comb begin
    rdec      = decode(32'(rd_addr_i), NUM_CH);
    rd_data_o = '0;
    case (rdec.sel)
      SEL_CTRL: rd_data_o = ctrl_i;
      SEL_CNTB: rd_data_o = cntb_i[rdec.ch];
      SEL_CMPB: rd_data_o = cmpb_i[rdec.ch];
      SEL_OBS:  rd_data_o = cnt_i[rdec.ch];
      default:  rd_data_o = '0;
    endcase
  end

endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_bank_pkg::*;
#(
  parameter int unsigned NUM_CH = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [NUM_CH-1:0] tick_en,
  output logic [NUM_CH-1:0] expire_o
);

  localparam int unsigned LAST = NUM_CH - 1;

  dec_t wdec;
  dec_t rdec;
  logic ctrl_wr;

  logic [DATA_W-1:0]             ctrl_q;
  logic [NUM_CH-1:0]             run;
  logic [NUM_CH-1:0]             load;
  logic [NUM_CH-1:0]             arld;
  logic [NUM_CH-1:0]             expire_now;
  logic [NUM_CH-1:0][DATA_W-1:0] cntb_all;
  logic [NUM_CH-1:0][DATA_W-1:0] cmpb_all;
  logic [NUM_CH-1:0][DATA_W-1:0] cnt_all;

  assign wdec    = decode(32'(wr_addr), NUM_CH);
  assign rdec    = decode(32'(rd_addr), NUM_CH);
  assign ctrl_wr = wr_en & (wdec.sel == SEL_CTRL);

  tmr_ctrl #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_i         (ctrl_wr),
    .wr_data_i    (wr_data),
    .expire_now_i (expire_now),
    .ctrl_o       (ctrl_q),
    .run_o        (run),
    .load_o       (load),
    .arld_o       (arld)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic wr_cntb;
    assign wr_cntb = wr_en & (wdec.sel == SEL_CNTB) & (wdec.ch == 8'(g));

    tmr_channel #(.DATA_W(DATA_W)) u_chan (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_cntb_i    (wr_cntb),
      .wr_data_i    (wr_data),
      .tick_i       (tick_en[g]),
      .run_i        (run[g]),
      .load_i       (load[g]),
      .arld_i       (arld[g]),
      .cntb_o       (cntb_all[g]),
      .cnt_o        (cnt_all[g]),
      .expire_now_o (expire_now[g]),
      .expire_o     (expire_o[g])
    );

    if (g != LAST) begin : g_cmp
      logic [DATA_W-1:0] cmpb_q;
      always_ff @(posedge clk) begin
        if (!rst_n)
          cmpb_q <= '0;
        else if (wr_en && wdec.sel == SEL_CMPB && wdec.ch == 8'(g))
          cmpb_q <= wr_data;
      end
      assign cmpb_all[g] = cmpb_q;
    end else begin : g_nocmp
      assign cmpb_all[g] = '0;
    end
  end

  tmr_rdmux #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rdmux (
    .rd_addr_i (rd_addr),
    .ctrl_i    (ctrl_q),
    .cntb_i    (cntb_all),
    .cmpb_i    (cmpb_all),
    .cnt_i     (cnt_all),
    .rd_data_o (rd_data)
  );

  // R3: the last channel has no compare storage
  always_comb begin
    if (rst_n && rdec.sel == SEL_CMPB && rdec.ch == 8'(LAST)) begin
      a_r3_no_cmp : assert (rd_data == '0);
    end
  end

  // R1: nothing expires in the first cycle out of reset
  a_r1_quiet : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> expire_o == '0);

endmodule

// File: tb/tmr_bank_tb_top.sv
module tmr_bank_tb_top;

  localparam int NCH = 5;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wr_en;
  logic [7:0]        wr_addr;
  logic [31:0]       wr_data;
  logic [7:0]        rd_addr;
  logic [31:0]       rd_data;
  logic [NCH-1:0]    tick_en;
  logic [NCH-1:0]    expire_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  tmr_bank dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .tick_en  (tick_en),
    .expire_o (expire_o)
  );

  // bench's own view of the control layout (R2)
  localparam int ST_BIT [NCH] = '{0, 8, 12, 16, 20};
  localparam int AR_BIT [NCH] = '{3, 11, 15, 19, 22};

  function automatic logic [7:0] a_cntb(input int ch); return 8'(4 + 4 * ch); endfunction
  function automatic logic [7:0] a_cmpb(input int ch); return 8'(5 + 4 * ch); endfunction
  function automatic logic [7:0] a_obs (input int ch); return 8'(6 + 4 * ch); endfunction
  function automatic logic [31:0] st_m(input int ch); return 32'(1) << ST_BIT[ch]; endfunction
  function automatic logic [31:0] mu_m(input int ch); return 32'(1) << (ST_BIT[ch] + 1); endfunction
  function automatic logic [31:0] ar_m(input int ch); return 32'(1) << AR_BIT[ch]; endfunction

  typedef struct packed {
    int ch; int n; int ar; int nticks; int nexp; int first; int obs; int st;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{0,  0, 0,  3, 1,  1, 0, 0},
    '{1,  5, 0,  8, 1,  6, 0, 0},
    '{2,  2, 1,  9, 3,  3, 2, 1},
    '{4,  1, 1,  5, 2,  2, 0, 1},
    '{3, 13, 0, 14, 1, 14, 0, 0},
    '{4,  3, 0,  4, 1,  4, 0, 0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_tick(input logic [7:0] a, input logic [31:0] d, input logic [NCH-1:0] t);
    wr_en = 1'b1; wr_addr = a; wr_data = d; tick_en = t;
    @(negedge clk);
    wr_en = 1'b0; tick_en = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic ticks(input int ch, input int n, output int nexp, output int first);
    nexp = 0; first = 0;
    for (int i = 1; i <= n; i++) begin
      tick_en[ch] = 1'b1;
      @(negedge clk);
      if (expire_o[ch]) begin
        nexp++;
        if (first == 0) first = i;
      end
    end
    tick_en = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    int ne, fi;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0; tick_en = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    rd(8'h00, v); check("R1 ctrl", v, 0);
    for (int c = 0; c < NCH; c++) begin
      rd(a_cntb(c), v); check("R1 cntb", v, 0);
      rd(a_obs(c), v);  check("R1 obs", v, 0);
      rd(a_cmpb(c), v); check("R1 cmpb", v, 0);
    end
    check("R1 expire", 32'(expire_o), 0);

    // table walk: R6 timing, R7 / R8 endings, R2 bit placement
    foreach (VEC[k]) begin
      vec_t e = VEC[k];
      logic [31:0] arv = (e.ar != 0) ? ar_m(e.ch) : 32'd0;
      wr(8'h00, 32'd0);
      wr(a_cntb(e.ch), 32'(e.n));
      wr(8'h00, mu_m(e.ch) | arv);
      rd(a_obs(e.ch), v); check("R4 load", v, 32'(e.n));
      wr(8'h00, st_m(e.ch) | arv);
      ticks(e.ch, e.nticks, ne, fi);
      check("R6 expiry count", 32'(ne), 32'(e.nexp));
      check("R6 first expiry tick", 32'(fi), 32'(e.first));
      rd(a_obs(e.ch), v); check("R7/R8 final count", v, 32'(e.obs));
      rd(8'h00, v); check("R2 R7 R8 start bit", 32'(v[ST_BIT[e.ch]]), 32'(e.st));
    end

    // R3: address map, read-only observation, missing compare buffer
    wr(8'h00, 32'd0);
    wr(a_cmpb(3), 32'h0000ABCD);
    rd(a_cmpb(3), v); check("R3 cmpb rw", v, 32'h0000ABCD);
    wr(a_cmpb(4), 32'h00001234);
    rd(a_cmpb(4), v); check("R3 last cmpb", v, 0);
    rd(a_obs(2), v);
    wr(a_obs(2), 32'h55);
    rd(a_obs(2), v2); check("R3 obs write ignored", v2, v);

    // R4: only a rising manual-update bit reloads
    wr(a_cntb(1), 32'd10);
    wr(8'h00, mu_m(1));
    rd(a_obs(1), v); check("R4 rise loads", v, 10);
    wr(a_cntb(1), 32'd20);
    wr(8'h00, mu_m(1));
    rd(a_obs(1), v); check("R4 level no reload", v, 10);
    wr(8'h00, 32'd0);
    wr(8'h00, mu_m(1));
    rd(a_obs(1), v); check("R4 second rise", v, 20);

    // R5: count, hold without ticks, stop
    wr(8'h00, st_m(1));
    ticks(1, 3, ne, fi);
    rd(a_obs(1), v); check("R5 decrement", v, 17);
    repeat (3) @(negedge clk);
    rd(a_obs(1), v); check("R5 no tick hold", v, 17);
    wr(8'h00, 32'd0);
    ticks(1, 4, ne, fi);
    rd(a_obs(1), v); check("R5 stopped ignores ticks", v, 17);

    // R11: tick during a load cycle does not decrement
    wr(8'h00, st_m(1));
    wr_tick(8'h00, st_m(1) | mu_m(1), 5'b00010);
    rd(a_obs(1), v); check("R11 load beats tick", v, 20);
    ticks(1, 1, ne, fi);
    rd(a_obs(1), v); check("R10 runs after load", v, 19);

    // R10: load and start in one write
    wr(a_cntb(2), 32'd7);
    wr(8'h00, 32'd0);
    wr(8'h00, st_m(2) | mu_m(2));
    rd(a_obs(2), v); check("R10 loaded", v, 7);
    ticks(2, 2, ne, fi);
    rd(a_obs(2), v); check("R10 counting", v, 5);

    // R9: expiry colliding with a write that keeps start at 1
    wr(a_cntb(1), 32'd1);
    wr(8'h00, 32'd0);
    wr(8'h00, mu_m(1));
    wr(8'h00, st_m(1));
    ticks(1, 1, ne, fi);
    rd(a_obs(1), v); check("R5 at zero", v, 0);
    wr_tick(8'h00, st_m(1) | 32'h400, 5'b00010);
    check("R6 pulse high", 32'(expire_o[1]), 1);
    rd(8'h00, v); check("R9 hw clear wins", v, 32'h400);
    @(negedge clk);
    check("R6 pulse one cycle", 32'(expire_o[1]), 0);
    rd(a_obs(1), v); check("R8 stays zero", v, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule